// File: doc/BRIEF.md
# Strobe Period Rate Meter

This block measures the average output data rate of a converter whose decimation ratio carries a 16-bit fractional part. When the ratio is fractional, the spacing of the data-ready strobes dithers between the floor and ceiling periods. A single period therefore says little. The meter counts reference clock cycles across a window of strobes that covers a whole dither cycle, so the floor and ceiling periods cancel out. The window length comes from the programmed fraction through an integer reciprocal. Software can also force a length of its own.

A start pulse latches the fraction, or the forced length, and computes the window. The meter then waits for the first strobe rising edge and counts cycles up to the final edge of the window. On that edge it raises a done flag and holds two results: the total cycle count and the number of periods it spans. Their ratio is the average period in reference cycles. Dividing into physical units is left to the consumer. The results are held registers qualified by the done flag. Nothing drains them, so the block applies no back-pressure and needs no valid/ready handshake. A counter overflow ends the run with an error flag instead of done.

Top module: `srm_rate_meter`

## Requirements
- R1: After reset, busy_o, done_o and error_o are 0, and total_cycles_o and periods_o are 0.
- R2: With a fraction of 0 and no override, the window is 2 strobe edges. This gives one period, so periods_o = 1.
- R3: With a fraction f in 1..32768 (f/65536 at most one half) and no override, the window is ceil(65536/f) + 1 strobe edges.
- R4: With a fraction f in 32769..65535 and no override, the window is ceil(65536/(65536 − f)) + 1 strobe edges. For example, f = 0xF7CF gives 33.
- R5: When ovr_en_i is 1 at start, the window is ovr_count_i, raised to 2 if it is below 2. The fraction has no effect on the result.
- R6: At completion, total_cycles_o equals the number of clock edges from the edge that registered the first counted strobe rise to the edge that registered the last one. periods_o equals the window minus 1.
- R7: The window is ready no later than 24 cycles after start. Strobe edges that arrive before then are not counted.
- R8: done_o rises on the clock edge that registers the final strobe rise of the window. done_o and the results then hold, and later strobes do not change them. A start clears done_o and sets busy_o on the next edge.
- R9: A start issued while a measurement is running abandons it. The new measurement follows the new settings and ignores the edges already counted.
- R10: If the cycle counter reaches 2^CW − 1 before the window closes, error_o is set, busy_o falls, and done_o stays 0. The next start clears error_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low reset |
| strobe_i | input | 1 | Data-ready strobe, synchronous to clk; rising edges are counted |
| start_i | input | 1 | Starts or restarts a measurement |
| frac_i | input | FW (16) | Fractional part of the decimation ratio, in units of 2^-16 |
| ovr_en_i | input | 1 | Use ovr_count_i as the window length |
| ovr_count_i | input | FW+1 (17) | Forced window length in strobe edges |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Results are valid |
| error_o | output | 1 | Cycle counter overflowed |
| total_cycles_o | output | CW (24) | Clock cycles spanned by the window |
| periods_o | output | FW+1 (17) | Strobe periods spanned by the window |

## Verification
The strobe pulses are driven on falling edges. The bench records the index of the rising edge that registers each pulse. It expects done_o in the same cycle as the window's final pulse, and expects total_cycles_o to equal the difference between the recorded indices of the first and final pulses. After each start the strobe stays low for 30 cycles, which is longer than the 24-cycle bound of R7. This makes the first counted pulse unambiguous. A deliberate pulse placed inside that gap checks that such pulses are ignored. The clearing of done_o is sampled one cycle after the start pulse. The overflow flag is sampled well after the cycle in which a narrow 8-bit counter must saturate.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CALC,
    ST_ARM,
    ST_MEAS
  } meas_state_e;
endpackage

// File: rtl/srm_recip_div.sv
// Sequential restoring divider computing 2^FW / divisor, one quotient bit per cycle.
module srm_recip_div #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kill,
  input  logic          load,
  input  logic [FW-1:0] divisor,
  output logic          done,
  output logic [FW:0]   quot,
  output logic [FW-1:0] rem
);
  localparam int STEPS = FW + 1;
  localparam int SW    = $clog2(STEPS + 1);
  localparam int WIDE  = 2 * FW + 2;

  logic [FW:0]   num_q;
  logic [FW-1:0] dvs_q;
  logic [SW-1:0] left_q;
  logic [FW:0]   trial;
  logic          fits;

  always_comb begin
    trial = {rem, num_q[FW]};
    fits  = (trial >= {1'b0, dvs_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q  <= '0;
      dvs_q  <= '0;
      left_q <= '0;
      quot   <= '0;
      rem    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (kill) begin
        if (load) begin
          num_q  <= (FW+1)'(1) << FW;
          dvs_q  <= divisor;
          quot   <= '0;
          rem    <= '0;
          left_q <= SW'(STEPS);
        end else begin
          left_q <= '0;
        end
      end else if (left_q != '0) begin
        if (fits) begin
          rem  <= FW'(trial - {1'b0, dvs_q});
          quot <= {quot[FW-1:0], 1'b1};
        end else begin
          rem  <= trial[FW-1:0];
          quot <= {quot[FW-1:0], 1'b0};
        end
        num_q  <= num_q << 1;
        left_q <= left_q - SW'(1);
        if (left_q == SW'(1)) done <= 1'b1;
      end
    end
  end

  // R3/R4: the quotient and remainder reconstruct the dividend exactly
  a_r3_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((WIDE'(quot) * WIDE'(dvs_q) + WIDE'(rem)) == (WIDE'(1) << FW)) && (rem < dvs_q));
endmodule

// File: rtl/srm_window_calc.sv
// Chooses the window length: forced, fixed for a zero fraction, or a ceiling reciprocal.
module srm_window_calc #(
  parameter int FW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [FW-1:0] frac,
  input  logic          ovr_en,
  input  logic [FW:0]   ovr_cnt,
  output logic          ready,
  output logic [FW:0]   window
);
  localparam logic [FW-1:0] HALF    = FW'(1) << (FW - 1);
  localparam logic [FW:0]   MIN_WIN = (FW+1)'(2);

  logic          need_div;
  logic          upper_half;
  logic [FW-1:0] dvs;
  logic          div_done;
  logic [FW:0]   quot;
  logic [FW-1:0] rem;

  always_comb begin
    need_div   = !ovr_en && (frac != '0);
    upper_half = (frac > HALF);
    dvs        = upper_half ? (~frac + FW'(1)) : frac;
  end

  srm_recip_div #(.FW(FW)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .kill    (go),
    .load    (go && need_div),
    .divisor (dvs),
    .done    (div_done),
    .quot    (quot),
    .rem     (rem)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready  <= 1'b0;
      window <= MIN_WIN;
    end else begin
      ready <= 1'b0;
      if (go) begin
        if (ovr_en) begin
          window <= (ovr_cnt < MIN_WIN) ? MIN_WIN : ovr_cnt;
          ready  <= 1'b1;
        end else if (frac == '0) begin
          window <= MIN_WIN;
          ready  <= 1'b1;
        end
      end else if (div_done) begin
        window <= quot + (FW+1)'(rem != '0) + (FW+1)'(1);
        ready  <= 1'b1;
      end
    end
  end

  // R2/R5: no window shorter than one period is ever produced
  a_r5_window_min: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (window >= MIN_WIN));
endmodule

// File: rtl/srm_period_counter.sv
// Edge-detects the strobe and counts reference cycles across the window.
module srm_period_counter
  import srm_pkg::*;
#(
  parameter int FW = 16,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          strobe,
  input  logic          win_ready,
  input  logic [FW:0]   window,
  output logic          busy,
  output logic          done,
  output logic          error,
  output logic [CW-1:0] total,
  output logic [FW:0]   periods
);
  localparam logic [CW-1:0] CMAX = '1;

  meas_state_e   state_q;
  logic          strb_q;
  logic          rise;
  logic [CW-1:0] cnt_q;
  logic [FW:0]   edges_q;
  logic [FW:0]   win_q;
  logic [FW:0]   edges_nx;

  always_comb begin
    rise     = strobe && !strb_q;
    edges_nx = edges_q + (FW+1)'(1);
    busy     = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      strb_q  <= 1'b0;
      cnt_q   <= '0;
      edges_q <= '0;
      win_q   <= '0;
      done    <= 1'b0;
      error   <= 1'b0;
      total   <= '0;
      periods <= '0;
    end else begin
      strb_q <= strobe;
      if (start) begin
        state_q <= ST_CALC;
        done    <= 1'b0;
        error   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_CALC: if (win_ready) begin
            win_q   <= window;
            state_q <= ST_ARM;
          end
          ST_ARM: if (rise) begin
            cnt_q   <= '0;
            edges_q <= (FW+1)'(1);
            state_q <= ST_MEAS;
          end
          ST_MEAS: begin
            if (cnt_q == CMAX) begin
              error   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + CW'(1);
              if (rise) begin
                if (edges_nx == win_q) begin
                  total   <= cnt_q + CW'(1);
                  periods <= win_q - (FW+1)'(1);
                  done    <= 1'b1;
                  state_q <= ST_IDLE;
                end else begin
                  edges_q <= edges_nx;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R8: start clears the result flag and begins a run
  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && busy));
  // R8: results hold until the next start
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(total) && $stable(periods)));
  // R10: an overflowed run never reports done
  a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  // R6: each period spans at least one cycle
  a_r6_total_ge: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (longint'(total) >= longint'(periods)));
  // R7: counting is armed only with a usable window
  a_r7_armed_window: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARM) |-> (win_q >= (FW+1)'(2)));
endmodule

// File: rtl/srm_rate_meter.sv
module srm_rate_meter #(
  parameter int FW = 16,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_i,
  input  logic          start_i,
  input  logic [FW-1:0] frac_i,
  input  logic          ovr_en_i,
  input  logic [FW:0]   ovr_count_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          error_o,
  output logic [CW-1:0] total_cycles_o,
  output logic [FW:0]   periods_o
);
  logic        win_ready;
  logic [FW:0] window;

  srm_window_calc #(.FW(FW)) u_calc (
    .clk     (clk),
    .rst_n   (rst_n),
    .go      (start_i),
    .frac    (frac_i),
    .ovr_en  (ovr_en_i),
    .ovr_cnt (ovr_count_i),
    .ready   (win_ready),
    .window  (window)
  );

  srm_period_counter #(.FW(FW), .CW(CW)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .strobe    (strobe_i),
    .win_ready (win_ready),
    .window    (window),
    .busy      (busy_o),
    .done      (done_o),
    .error     (error_o),
    .total     (total_cycles_o),
    .periods   (periods_o)
  );
endmodule

// File: tb/srm_rate_meter_test.sv
module srm_rate_meter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic        start = 1'b0;
  logic        start_s = 1'b0;
  logic [15:0] frac = '0;
  logic        ovr_en = 1'b0;
  logic [16:0] ovr_cnt = '0;
  logic        busy, done, error;
  logic [23:0] total;
  logic [16:0] periods;
  logic        busy_s, done_s, error_s;
  logic [7:0]  total_s;
  logic [16:0] periods_s;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  int done_rise_cyc = -1;
  logic done_d = 1'b0;
  int edge_at [0:255];
  int n_edge = 0;

  always #5 clk = ~clk;

  srm_rate_meter uut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .start_i(start),
    .frac_i(frac), .ovr_en_i(ovr_en), .ovr_count_i(ovr_cnt),
    .busy_o(busy), .done_o(done), .error_o(error),
    .total_cycles_o(total), .periods_o(periods));

  srm_rate_meter #(.FW(16), .CW(8)) uut_small (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .start_i(start_s),
    .frac_i(16'd0), .ovr_en_i(1'b0), .ovr_count_i(17'd0),
    .busy_o(busy_s), .done_o(done_s), .error_o(error_s),
    .total_cycles_o(total_s), .periods_o(periods_s));

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (done && !done_d) done_rise_cyc = cyc;
    done_d = done;
  end

  task automatic chk(string req, string what, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int win_exp(int f, bit oe, int oc);
    int d;
    if (oe) return (oc < 2) ? 2 : oc;
    if (f == 0) return 2;
    d = (f <= 32768) ? f : 65536 - f;
    return (65536 + d - 1) / d + 1;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic gen(int n, int lo, int span);
    for (int i = 0; i < n; i++) begin
      int p;
      @(negedge clk); strobe = 1'b1;
      edge_at[n_edge] = cyc + 1;
      n_edge++;
      @(negedge clk); strobe = 1'b0;
      p = lo + int'($urandom % span);
      repeat (p - 2) @(negedge clk);
    end
  endtask

  task automatic measure(string req, int f, bit oe, int oc, bit glitch);
    int w;
    frac = 16'(f); ovr_en = oe; ovr_cnt = 17'(oc);
    w = win_exp(f, oe, oc);
    pulse_start();
    chk("R8", "done after start", longint'(done), 0);
    chk("R8", "busy after start", longint'(busy), 1);
    if (glitch) begin
      repeat (3) @(negedge clk);
      strobe = 1'b1; @(negedge clk); strobe = 1'b0;  // R7: before window ready
      repeat (26) @(negedge clk);
    end else begin
      repeat (30) @(negedge clk);
    end
    n_edge = 0;
    gen(w + 2, 3, 10);
    chk(req, "done", longint'(done), 1);
    chk(req, "periods", longint'(periods), w - 1);
    chk("R6", "total", longint'(total), edge_at[w-1] - edge_at[0]);
    chk("R8", "done rise cycle", done_rise_cyc, edge_at[w-1]);
    chk("R10", "no error", longint'(error), 0);
    chk("R8", "busy low", longint'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int seed;
    seed = int'($urandom(32'h5eed));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy", longint'(busy), 0);
    chk("R1", "done", longint'(done), 0);
    chk("R1", "error", longint'(error), 0);
    chk("R1", "total", longint'(total), 0);
    chk("R1", "periods", longint'(periods), 0);

    measure("R2", 0, 1'b0, 0, 1'b0);
    measure("R3", 16'h8000, 1'b0, 0, 1'b0);
    measure("R3", 16'h0800, 1'b0, 0, 1'b0);
    measure("R3", 16'h0801, 1'b0, 0, 1'b0);
    measure("R4", 16'h8001, 1'b0, 0, 1'b0);
    measure("R4", 16'hF7CF, 1'b0, 0, 1'b0);
    measure("R5", 16'hF7CF, 1'b1, 5, 1'b0);
    measure("R5", 16'h0800, 1'b1, 1, 1'b0);
    measure("R5", 16'h1234, 1'b1, 0, 1'b0);
    measure("R7", 16'h8000, 1'b0, 0, 1'b1);

    for (int k = 0; k < 10; k++) begin
      int f, d;
      do begin
        f = int'($urandom % 65536);
        d = (f <= 32768) ? f : 65536 - f;
      end while (f != 0 && d < 1500);
      measure((f <= 32768) ? "R3" : "R4", f, 1'b0, 0, 1'b0);
    end

    // R9: restart mid-run with new settings
    frac = 16'hF7CF; ovr_en = 1'b0;
    pulse_start();
    repeat (30) @(negedge clk);
    n_edge = 0;
    gen(5, 4, 4);
    chk("R9", "still busy", longint'(busy), 1);
    chk("R9", "no done yet", longint'(done), 0);
    frac = 16'h0000;
    pulse_start();
    repeat (30) @(negedge clk);
    n_edge = 0;
    gen(4, 5, 6);
    chk("R9", "done", longint'(done), 1);
    chk("R9", "periods", longint'(periods), 1);
    chk("R9", "total", longint'(total), edge_at[1] - edge_at[0]);

    // R10: overflow on an 8-bit counter
    @(negedge clk); start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    repeat (30) @(negedge clk);
    n_edge = 0;
    gen(1, 300, 1);
    chk("R10", "error set", longint'(error_s), 1);
    chk("R10", "done clear", longint'(done_s), 0);
    chk("R10", "busy clear", longint'(busy_s), 0);
    @(negedge clk); start_s = 1'b1;
    @(negedge clk); start_s = 1'b0;
    chk("R10", "error cleared", longint'(error_s), 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule